// File: doc/BRIEF.md
# Floating-Point Control and Status Register

This block keeps the floating-point unit's control and status state in one place. That state is a 3-bit dynamic rounding mode and five sticky exception flags. Software reaches it through three register views over one access port: the whole 32-bit register, the rounding-mode field alone, or the flag field alone. Every access returns the value held before the access. When the write strobe is set, the same access also stores new data, so one access is an atomic swap.

Retiring arithmetic operations send exception pulses. The block ORs them into the stored flags, and the flags stay set until software overwrites them. No trap is raised. The block also turns an instruction's rounding field into the rounding mode that takes effect. The code 111 means "use the stored mode", and any other code is used as it is. The block flags the result when that mode is not one of the five defined modes.

Top module: `fp_ctl_status_reg`

## Requirements
- R1: Reset (synchronous, active high) clears the rounding mode to 000 (round to nearest, ties to even) and clears all five flags.
- R2: The full view (`csr_view` = 00) reads `{24'b0, mode[2:0], flags[4:0]}`. The mode is in bits 7:5 and the flags are in bits 4:0. The flag order from bit 4 down to bit 0 is: invalid, divide-by-zero, overflow, underflow, inexact. Written bits 31:8 are dropped and always read as zero.
- R3: Every access returns on `csr_rdata`, in the same cycle, the value held before that access. A write (`csr_wr`=1) takes effect from the next cycle.
- R4: The mode view (`csr_view` = 01) reads the mode zero-extended into bits 2:0. It writes the mode from `csr_wdata[2:0]` and leaves the flags alone.
- R5: The flag view (`csr_view` = 10) reads the flags zero-extended into bits 4:0. It writes the flags from `csr_wdata[4:0]` and leaves the mode alone.
- R6: A cycle with `acc_valid`=1 ORs `acc_flags` into the stored flags. Set flags are never cleared except by a CSR write or by reset.
- R7: When a CSR write that covers the flag field (full or flag view) coincides with accrual, the written value wins. An accrual that coincides with a mode-view write is still applied.
- R8: `eff_rm` equals the stored mode when `insn_rm` = 111. Otherwise it equals `insn_rm`. The output is combinational.
- R9: `rm_reserved` is 1 exactly when the effective code is 101, 110 or 111. This means static codes 101 and 110, or a stored dynamic mode of 101 to 111.
- R10: View code 11 writes nothing and reads zero.
- R11: A read without the write strobe, or a cycle with no valid access, leaves the mode and flags unchanged. `csr_rdata` is zero when `csr_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_valid | input | 1 | An access happens this cycle |
| csr_wr | input | 1 | The access also writes (swap) |
| csr_view | input | 2 | 00 full, 01 mode, 10 flags, 11 none |
| csr_wdata | input | 32 | Data to write |
| csr_rdata | output | 32 | Value held before the access |
| acc_valid | input | 1 | Exception pulse from a retiring operation |
| acc_flags | input | 5 | Flags to accrue, in the R2 bit order |
| insn_rm | input | 3 | Instruction rounding field |
| eff_rm | output | 3 | Effective rounding mode |
| rm_reserved | output | 1 | Effective mode is a reserved code |

## Verification
The full view is swept over all 256 values of the low byte, each with nonzero upper bits. Each swap's read-back must show the previous byte and zeros above bit 7, which separates swap timing from upper-bit masking. Mode resolution is tried for every pair of instruction code and stored mode. This separates the dynamic path from the static path and static reserved codes from dynamic ones. Accrual is run alone, then against a flag write, then against a mode write, which shows both the write-wins rule and the rule that a write leaves the other field alone.

// File: rtl/fpcsr_pkg.sv
package fpcsr_pkg;

    localparam int RM_W     = 3;
    localparam int FLAG_W   = 5;
    localparam int FIELD_W  = RM_W + FLAG_W;

    localparam logic [RM_W-1:0] RM_RNE = 3'b000;
    localparam logic [RM_W-1:0] RM_RMM = 3'b100;
    localparam logic [RM_W-1:0] RM_DYN = 3'b111;

    typedef enum logic [1:0] {
        VIEW_FULL  = 2'b00,
        VIEW_RM    = 2'b01,
        VIEW_FLAGS = 2'b10,
        VIEW_NONE  = 2'b11
    } csr_view_e;

    typedef struct packed {
        logic nv;
        logic dz;
        logic of;
        logic uf;
        logic nx;
    } fflags_t;

    typedef struct packed {
        logic [RM_W-1:0] rm;
        fflags_t         flags;
    } fstate_t;

    // Codes above the last defined mode are reserved.
    function automatic logic rm_code_reserved(input logic [RM_W-1:0] code);
        return code > RM_RMM;
    endfunction

endpackage

// File: rtl/fpcsr_view_port.sv
module fpcsr_view_port
    import fpcsr_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic                 access,
    input  logic                 write,
    input  logic [1:0]           view,
    input  logic [XLEN-1:0]      wdata,
    input  fstate_t              cur,
    output logic [XLEN-1:0]      rdata,
    output logic                 wr_rm,
    output logic                 wr_flags,
    output logic [RM_W-1:0]      new_rm,
    output fflags_t              new_flags
);
    localparam int PAD_FULL  = XLEN - FIELD_W;
    localparam int PAD_RM    = XLEN - RM_W;
    localparam int PAD_FLAGS = XLEN - FLAG_W;

    csr_view_e view_e;
    logic      hi_bits_unused;

    assign view_e         = csr_view_e'(view);
    assign hi_bits_unused = ^wdata[XLEN-1:FIELD_W];

    always_comb begin
        rdata     = '0;
        wr_rm     = 1'b0;
        wr_flags  = 1'b0;
        new_rm    = cur.rm;
        new_flags = cur.flags;
        if (access) begin
            unique case (view_e)
                VIEW_FULL: begin
                    rdata     = {{PAD_FULL{1'b0}}, cur};
                    wr_rm     = write;
                    wr_flags  = write;
                    new_rm    = wdata[FIELD_W-1:FLAG_W];
                    new_flags = fflags_t'(wdata[FLAG_W-1:0]);
                end
                VIEW_RM: begin
                    rdata  = {{PAD_RM{1'b0}}, cur.rm};
                    wr_rm  = write;
                    new_rm = wdata[RM_W-1:0];
                end
                VIEW_FLAGS: begin
                    rdata     = {{PAD_FLAGS{1'b0}}, cur.flags};
                    wr_flags  = write;
                    new_flags = fflags_t'(wdata[FLAG_W-1:0]);
                end
                default: rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/fpcsr_state_regs.sv
module fpcsr_state_regs
    import fpcsr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_rm,
    input  logic [RM_W-1:0]   new_rm,
    input  logic              wr_flags,
    input  fflags_t           new_flags,
    input  logic              acc_valid,
    input  logic [FLAG_W-1:0] acc_flags,
    output fstate_t           state
);
    fstate_t state_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q.rm    <= RM_RNE;
            state_q.flags <= '0;
        end else begin
            if (wr_rm)
                state_q.rm <= new_rm;
            // A software write to the flags overrides a coincident pulse.
            if (wr_flags)
                state_q.flags <= new_flags;
            else if (acc_valid)
                state_q.flags <= state_q.flags | fflags_t'(acc_flags);
        end
    end

    assign state = state_q;
endmodule

// File: rtl/fpcsr_rm_resolve.sv
module fpcsr_rm_resolve
    import fpcsr_pkg::*;
(
    input  logic [RM_W-1:0] insn_rm,
    input  logic [RM_W-1:0] stored_rm,
    output logic [RM_W-1:0] eff_rm,
    output logic            reserved
);
    always_comb begin
        eff_rm   = (insn_rm == RM_DYN) ? stored_rm : insn_rm;
        reserved = rm_code_reserved(eff_rm);
    end
endmodule

// File: rtl/fp_ctl_status_reg.sv
module fp_ctl_status_reg
    import fpcsr_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              csr_valid,
    input  logic              csr_wr,
    input  logic [1:0]        csr_view,
    input  logic [XLEN-1:0]   csr_wdata,
    output logic [XLEN-1:0]   csr_rdata,
    input  logic              acc_valid,
    input  logic [FLAG_W-1:0] acc_flags,
    input  logic [RM_W-1:0]   insn_rm,
    output logic [RM_W-1:0]   eff_rm,
    output logic              rm_reserved
);
    fstate_t           state_q;
    logic              wr_rm;
    logic              wr_flags;
    logic [RM_W-1:0]   new_rm;
    fflags_t           new_flags;

    fpcsr_view_port #(.XLEN(XLEN)) view_i (
        .access    (csr_valid),
        .write     (csr_wr),
        .view      (csr_view),
        .wdata     (csr_wdata),
        .cur       (state_q),
        .rdata     (csr_rdata),
        .wr_rm     (wr_rm),
        .wr_flags  (wr_flags),
        .new_rm    (new_rm),
        .new_flags (new_flags)
    );

    fpcsr_state_regs regs_i (
        .clk       (clk),
        .rst       (rst),
        .wr_rm     (wr_rm),
        .new_rm    (new_rm),
        .wr_flags  (wr_flags),
        .new_flags (new_flags),
        .acc_valid (acc_valid),
        .acc_flags (acc_flags),
        .state     (state_q)
    );

    fpcsr_rm_resolve resolve_i (
        .insn_rm   (insn_rm),
        .stored_rm (state_q.rm),
        .eff_rm    (eff_rm),
        .reserved  (rm_reserved)
    );
endmodule

// File: rtl/fpcsr_checker.sv
module fpcsr_checker #(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst,
    input logic            csr_valid,
    input logic            csr_wr,
    input logic [1:0]      csr_view,
    input logic [XLEN-1:0] csr_wdata,
    input logic [XLEN-1:0] csr_rdata,
    input logic            acc_valid,
    input logic [4:0]      acc_flags,
    input logic [2:0]      insn_rm,
    input logic [2:0]      eff_rm,
    input logic            rm_reserved,
    input logic [7:0]      state_q
);
    logic flag_write;
    assign flag_write = csr_valid && csr_wr && (csr_view == 2'b00 || csr_view == 2'b10);

    a_r2_upper_zero: assert property (@(posedge clk) disable iff (rst)
        csr_rdata[XLEN-1:8] == '0);

    a_r3_full_swap: assert property (@(posedge clk) disable iff (rst)
        (csr_valid && csr_wr && csr_view == 2'b00) |=> (state_q == $past(csr_wdata[7:0])));

    a_r6_sticky: assert property (@(posedge clk) disable iff (rst)
        !flag_write |=> ((state_q[4:0] & $past(state_q[4:0])) == $past(state_q[4:0])));

    a_r6_accrue: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && !flag_write) |=> ((state_q[4:0] & $past(acc_flags)) == $past(acc_flags)));

    a_r8_dynamic: assert property (@(posedge clk) disable iff (rst)
        (insn_rm == 3'b111) |-> (eff_rm == state_q[7:5]));

    a_r9_static_reserved: assert property (@(posedge clk) disable iff (rst)
        (insn_rm == 3'b101 || insn_rm == 3'b110) |-> rm_reserved);

    a_r10_no_view: assert property (@(posedge clk) disable iff (rst)
        (csr_valid && csr_view == 2'b11) |-> (csr_rdata == '0));

    a_r11_read_only: assert property (@(posedge clk) disable iff (rst)
        (!(csr_valid && csr_wr) && !acc_valid) |=> $stable(state_q));
endmodule

bind fp_ctl_status_reg fpcsr_checker #(.XLEN(XLEN)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .csr_valid   (csr_valid),
    .csr_wr      (csr_wr),
    .csr_view    (csr_view),
    .csr_wdata   (csr_wdata),
    .csr_rdata   (csr_rdata),
    .acc_valid   (acc_valid),
    .acc_flags   (acc_flags),
    .insn_rm     (insn_rm),
    .eff_rm      (eff_rm),
    .rm_reserved (rm_reserved),
    .state_q     (state_q)
);

// File: tb/fp_ctl_status_reg_tb_top.sv
`timescale 1ns/1ps
module fp_ctl_status_reg_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        csr_valid = 1'b0;
    logic        csr_wr = 1'b0;
    logic [1:0]  csr_view = 2'b00;
    logic [31:0] csr_wdata = '0;
    logic [31:0] csr_rdata;
    logic        acc_valid = 1'b0;
    logic [4:0]  acc_flags = '0;
    logic [2:0]  insn_rm = '0;
    logic [2:0]  eff_rm;
    logic        rm_reserved;

    int n_checks = 0;
    int n_fail   = 0;
    logic [2:0] m_rm = 3'b000;
    logic [4:0] m_fl = 5'b00000;

    always #2 clk = ~clk;

    fp_ctl_status_reg #(.XLEN(32)) dut_i (
        .clk(clk), .rst(rst), .csr_valid(csr_valid), .csr_wr(csr_wr),
        .csr_view(csr_view), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
        .acc_valid(acc_valid), .acc_flags(acc_flags), .insn_rm(insn_rm),
        .eff_rm(eff_rm), .rm_reserved(rm_reserved)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_read(input logic [1:0] view);
        case (view)
            2'b00:   return {24'b0, m_rm, m_fl};
            2'b01:   return {29'b0, m_rm};
            2'b10:   return {27'b0, m_fl};
            default: return 32'b0;
        endcase
    endfunction

    // One access cycle: drive at negedge, check the read data, then update the model.
    task automatic do_acc(input logic v, input logic wr, input logic [1:0] view,
                          input logic [31:0] wd, input logic av, input logic [4:0] af,
                          input string req);
        @(negedge clk);
        csr_valid = v; csr_wr = wr; csr_view = view; csr_wdata = wd;
        acc_valid = av; acc_flags = af;
        #1;
        chk(req, csr_rdata, v ? exp_read(view) : 32'b0);
        @(posedge clk);
        if (v && wr && view == 2'b00) m_rm = wd[7:5];
        if (v && wr && view == 2'b01) m_rm = wd[2:0];
        if (v && wr && (view == 2'b00 || view == 2'b10)) m_fl = wd[4:0];
        else if (av) m_fl = m_fl | af;
    endtask

    task automatic idle();
        @(negedge clk);
        csr_valid = 0; csr_wr = 0; csr_view = 0; csr_wdata = 0;
        acc_valid = 0; acc_flags = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        // R1: reset state
        do_acc(1, 0, 2'b00, 32'hFFFF_FFFF, 0, 0, "R1 reset full read");
        @(negedge clk); insn_rm = 3'b111; #1;
        chk("R1 reset mode via dynamic", {29'b0, eff_rm}, 32'd0);

        // R2/R3: swap sweep over every low byte, upper bits nonzero
        for (int v = 0; v < 256; v++) begin
            logic [7:0] b;
            b = v[7:0];
            do_acc(1, 1, 2'b00, {~b, b ^ 8'h5A, ~b, b}, 0, 0, "R2_R3 full swap");
        end
        do_acc(1, 0, 2'b00, 0, 0, 0, "R3 last swap visible");

        // R4/R5: field views, each leaving the other field alone
        do_acc(1, 1, 2'b00, 32'h0000_0000, 0, 0, "R2 clear");
        do_acc(1, 1, 2'b01, 32'hFFFF_FFFB, 0, 0, "R4 mode write");
        do_acc(1, 0, 2'b00, 0, 0, 0, "R4 flags untouched");
        do_acc(1, 1, 2'b10, 32'hFFFF_FFF5, 0, 0, "R5 flag write");
        do_acc(1, 0, 2'b00, 0, 0, 0, "R5 mode untouched");
        do_acc(1, 0, 2'b01, 0, 0, 0, "R4 mode read");
        do_acc(1, 0, 2'b10, 0, 0, 0, "R5 flag read");

        // R6: sticky accrual
        do_acc(1, 1, 2'b10, 0, 0, 0, "R6 clear flags");
        do_acc(0, 0, 2'b00, 0, 1, 5'b00001, "R6 accrue nx");
        do_acc(0, 0, 2'b00, 0, 1, 5'b10000, "R6 accrue nv");
        do_acc(0, 0, 2'b00, 0, 1, 5'b00000, "R6 empty pulse");
        do_acc(1, 0, 2'b10, 0, 0, 0, "R6 flags sticky");
        chk("R6 expected model", {27'b0, m_fl}, 32'h11);

        // R7: write versus accrual
        do_acc(1, 1, 2'b10, 32'h0000_0002, 1, 5'b01000, "R7 flag write wins");
        do_acc(1, 0, 2'b10, 0, 0, 0, "R7 flag write result");
        chk("R7 expected model", {27'b0, m_fl}, 32'h02);
        do_acc(1, 1, 2'b00, 32'h0000_0060, 1, 5'b00100, "R7 full write wins");
        do_acc(1, 0, 2'b00, 0, 0, 0, "R7 full write result");
        do_acc(1, 1, 2'b01, 32'h0000_0001, 1, 5'b00100, "R7 mode write keeps accrual");
        do_acc(1, 0, 2'b00, 0, 0, 0, "R7 mode write result");
        chk("R7 expected model", {24'b0, m_rm, m_fl}, 32'h24);

        // R10/R11: no view, read-only, no access
        do_acc(1, 1, 2'b11, 32'hFFFF_FFFF, 0, 0, "R10 no view read zero");
        do_acc(1, 0, 2'b00, 0, 0, 0, "R10 no state change");
        do_acc(1, 0, 2'b01, 0, 0, 0, "R11 read only");
        do_acc(0, 1, 2'b00, 32'hFFFF_FFFF, 0, 0, "R11 no access read zero");
        do_acc(1, 0, 2'b00, 0, 0, 0, "R11 unchanged");

        // R8/R9: every instruction code against every stored mode
        for (int s = 0; s < 8; s++) begin
            do_acc(1, 1, 2'b01, s, 0, 0, "R8 set stored mode");
            idle();
            for (int i = 0; i < 8; i++) begin
                logic [2:0] e;
                @(negedge clk);
                insn_rm = i[2:0];
                #1;
                e = (i == 7) ? s[2:0] : i[2:0];
                chk("R8 effective mode", {29'b0, eff_rm}, {29'b0, e});
                chk("R9 reserved", {31'b0, rm_reserved}, {31'b0, (e > 3'd4)});
            end
        end

        // R1: reset from a nonzero state
        do_acc(1, 1, 2'b00, 32'h0000_00FF, 0, 0, "R1 preload");
        @(negedge clk); rst = 1; csr_valid = 0; csr_wr = 0;
        @(posedge clk);
        @(negedge clk); rst = 0;
        m_rm = 0; m_fl = 0;
        do_acc(1, 0, 2'b00, 0, 0, 0, "R1 reset clears");

        idle();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule